// File: doc/BRIEF.md
# Soft-Start and Soft-Stop Reference Ramp Sequencer

This block drives the digital output-voltage reference of one step-down regulator channel. When the channel is enabled, the block waits for a programmed start delay. It then raises the reference code one step at a time, from zero up to a target code. When the channel is disabled, it waits for a programmed stop delay. It then lowers the code one step at a time until the code reaches a discharge-threshold code. At that point the channel returns to idle with a zero reference.

Every timing value counts a 1 µs timebase strobe, `tick_i`. One reference code step equals 50 mV. Each configuration word packs two fields. The upper six bits hold a delay in units of 250 ticks. The lower ten bits hold the number of ticks the reference stays at each level. The block also drives a pulse-enable output for the modulator and a soft-start-active flag. Four instances can place their flags at bit positions 0 to 3 of a shared status word, one bit per channel in channel order.

Top module: `soft_ramp_seq`

## Requirements
- R1: After reset, `ref_o`, `pulse_en_o` and `ss_active_o` are 0, and the block is idle.
- R2: After `en_i` rises from idle, `pulse_en_o` rises once `rise_cfg_i[15:10] * 250` ticks have been counted. A delay field of 0 makes the up ramp start on the first tick.
- R3: During the up ramp, `ref_o` rises by exactly 1 after every `rise_cfg_i[9:0]` ticks, where a field of 0 acts as 1. The ramp stops at `target_i`, and `ref_o` then holds while `en_i` stays high.
- R4: After `en_i` falls in the on state, `ref_o` holds for `fall_cfg_i[15:10] * 250` ticks. A field of 0 means the down ramp starts on the first tick.
- R5: During the down ramp, `ref_o` falls by exactly 1 after every `fall_cfg_i[9:0]` ticks, where 0 acts as 1. Once `ref_o <= thresh_i`, the block goes idle with `ref_o` = 0 and `pulse_en_o` = 0.
- R6: `pulse_en_o` is high from the cycle the up ramp starts until the down ramp ends. While it is low, `ref_o` is 0.
- R7: `ss_active_o` is high during the start delay. It stays high during the up ramp until `ref_o` equals `target_i`. It is low in every other state.
- R8: Dropping `en_i` during the start delay or the up ramp goes to the stop delay. The down ramp then starts from the current code. If pulses were never started, `pulse_en_o` stays low.
- R9: Raising `en_i` during the stop delay or the down ramp goes straight back to the up ramp from the current code, with no new start delay.
- R10: No delay or step advances in a cycle without `tick_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Channel enable request |
| tick_i | input | 1 | 1 µs timebase strobe, one cycle wide |
| rise_cfg_i | input | 16 | Start delay [15:10] and up-step ticks [9:0] |
| fall_cfg_i | input | 16 | Stop delay [15:10] and down-step ticks [9:0] |
| target_i | input | CODE_W | Target reference code, in 50 mV units |
| thresh_i | input | CODE_W | Discharge-threshold code |
| ref_o | output | CODE_W | Reference code |
| pulse_en_o | output | 1 | Modulator pulse enable |
| ss_active_o | output | 1 | Soft start in progress |

## Verification
A wrong state or counter value shows up at the ports in one of three ways: `pulse_en_o` changes edge in the wrong cycle, `ss_active_o` stays high when it should have cleared, or `ref_o` moves at the wrong time or by more than one code. A cycle-level bench model compares all three outputs on every cycle, so any error is reported in the first cycle in which it shows. Delay-counter errors can stay hidden for up to 250 ticks per unit before the late or early ramp start makes them visible. Aborting and resuming in the middle of a ramp checks that the code carries across the change of direction.

// File: rtl/soft_ramp_pkg.sv
package soft_ramp_pkg;
  localparam int unsigned DLY_W  = 6;
  localparam int unsigned STEP_W = 10;

  typedef struct packed {
    logic [DLY_W-1:0]  dly;
    logic [STEP_W-1:0] step;
  } ramp_cfg_t;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_START_DLY,
    SQ_RAMP_UP,
    SQ_ON,
    SQ_STOP_DLY,
    SQ_RAMP_DN
  } seq_st_e;
endpackage

// File: rtl/seq_evt_cnt.sv
// Counts events; done_o flags the event that completes lim_i (lim 0 acts as 1).
module seq_evt_cnt #(
  parameter int unsigned W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         ev_i,
  input  logic [W-1:0] lim_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;
  logic [W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;
  assign done_o  = ev_i && (cnt_inc >= {1'b0, lim_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (clr_i||done_o) cnt_q <= '0;
    else if (ev_i)          cnt_q <= cnt_inc[W-1:0];
  end
endmodule

// File: rtl/soft_ramp_seq.sv
module soft_ramp_seq
  import soft_ramp_pkg::*;
#(
  parameter int unsigned CODE_W         = 8,
  parameter int unsigned TICKS_PER_UNIT = 250
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic [15:0]       rise_cfg_i,
  input  logic [15:0]       fall_cfg_i,
  input  logic [CODE_W-1:0] target_i,
  input  logic [CODE_W-1:0] thresh_i,
  output logic [CODE_W-1:0] ref_o,
  output logic              pulse_en_o,
  output logic              ss_active_o
);
  localparam int unsigned DIV_W = $clog2(TICKS_PER_UNIT + 1);
  localparam logic [DIV_W-1:0] DIV_LIM = DIV_W'(TICKS_PER_UNIT);

  ramp_cfg_t rise_cfg, fall_cfg;
  assign rise_cfg = ramp_cfg_t'(rise_cfg_i);
  assign fall_cfg = ramp_cfg_t'(fall_cfg_i);

  seq_st_e           st_q, st_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic              live_q, live_d;
  logic              st_chg, unit_tick, unit_done, step_done, dly_done;
  logic [DLY_W-1:0]  dly_sel;
  logic [STEP_W-1:0] step_sel;

  assign st_chg   = (st_d != st_q);
  assign dly_sel  = (st_q == SQ_STOP_DLY) ? fall_cfg.dly  : rise_cfg.dly;
  assign step_sel = (st_q == SQ_RAMP_DN)  ? fall_cfg.step : rise_cfg.step;
  assign dly_done = (dly_sel == '0) ? tick_i : unit_done;

  // 250-tick unit divider, delay unit counter, per-step tick counter
  seq_evt_cnt #(.W(DIV_W)) u_div (
    .clk_i, .rst_ni, .clr_i(st_chg), .ev_i(tick_i), .lim_i(DIV_LIM), .done_o(unit_tick)
  );
  seq_evt_cnt #(.W(DLY_W)) u_dly (
    .clk_i, .rst_ni, .clr_i(st_chg), .ev_i(unit_tick), .lim_i(dly_sel), .done_o(unit_done)
  );
  seq_evt_cnt #(.W(STEP_W)) u_step (
    .clk_i, .rst_ni, .clr_i(st_chg), .ev_i(tick_i), .lim_i(step_sel), .done_o(step_done)
  );

  always_comb begin
    st_d   = st_q;
    code_d = code_q;
    live_d = live_q;
    unique case (st_q)
      SQ_IDLE: if (en_i) begin
        st_d   = SQ_START_DLY;
        code_d = '0;
      end
      SQ_START_DLY:
        if (!en_i)         st_d = SQ_STOP_DLY;
        else if (dly_done) st_d = SQ_RAMP_UP;
      SQ_RAMP_UP:
        if (!en_i) st_d = SQ_STOP_DLY;
        else if (code_q >= target_i) begin
          code_d = target_i;
          st_d   = SQ_ON;
        end else if (step_done) code_d = code_q + 1'b1;
      SQ_ON: if (!en_i) st_d = SQ_STOP_DLY;
      SQ_STOP_DLY:
        if (en_i)          st_d = SQ_RAMP_UP;
        else if (dly_done) st_d = SQ_RAMP_DN;
      SQ_RAMP_DN:
        if (en_i) st_d = SQ_RAMP_UP;
        else if (code_q <= thresh_i) begin
          st_d   = SQ_IDLE;
          code_d = '0;
          live_d = 1'b0;
        end else if (step_done) code_d = code_q - 1'b1;
      default: st_d = SQ_IDLE;
    endcase
    if (st_d == SQ_RAMP_UP) live_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SQ_IDLE;
      code_q <= '0;
      live_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      code_q <= code_d;
      live_q <= live_d;
    end
  end

  assign ref_o       = code_q;
  assign pulse_en_o  = live_q;
  assign ss_active_o = (st_q == SQ_START_DLY) || ((st_q == SQ_RAMP_UP) && (code_q != target_i));
endmodule

// File: rtl/soft_ramp_seq_chk.sv
module soft_ramp_seq_chk #(
  parameter int unsigned CODE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              tick_i,
  input logic [CODE_W-1:0] target_i,
  input logic [CODE_W-1:0] ref_o,
  input logic              pulse_en_o,
  input logic              ss_active_o
);
  AST_REF_ZERO_NO_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pulse_en_o |-> ref_o == '0); // R6
  AST_SS_BELOW_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ss_active_o && pulse_en_o) |-> ref_o != target_i); // R7
  AST_SS_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ss_active_o |-> $past(en_i)); // R8
  AST_UP_ONE_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_en_o && $past(pulse_en_o) && ref_o > $past(ref_o)) |-> ref_o == $past(ref_o) + 1'b1); // R3
  AST_DOWN_ONE_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_en_o && $past(pulse_en_o) && ref_o < $past(ref_o) && $past(ref_o) <= $past(target_i))
      |-> ref_o == $past(ref_o) - 1'b1); // R5
  AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_en_o && $past(pulse_en_o) && !$past(tick_i) && $past(ref_o) <= $past(target_i))
      |-> $stable(ref_o)); // R10
endmodule

bind soft_ramp_seq soft_ramp_seq_chk #(.CODE_W(CODE_W)) u_chk (.*);

// File: tb/tb_soft_ramp_seq.sv
`timescale 1ns/1ps
module tb_soft_ramp_seq;
  localparam int CW  = 8;
  localparam int TPU = 250;

  logic          clk_i = 1'b0, rst_ni = 1'b0, en_i = 1'b0, tick_i = 1'b1;
  logic [15:0]   rise_cfg_i = '0, fall_cfg_i = '0;
  logic [CW-1:0] target_i = '0, thresh_i = '0, ref_o;
  logic          pulse_en_o, ss_active_o;

  int checks = 0, fails = 0, tick_mode = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  soft_ramp_seq #(.CODE_W(CW), .TICKS_PER_UNIT(TPU)) dut (.*);

  // reference model
  typedef enum int {M_IDLE, M_SD, M_UP, M_ON, M_PD, M_DN} mst_e;
  mst_e m_st = M_IDLE;
  int m_code = 0, m_el = 0;
  bit m_live = 0;

  function automatic int lim1(input int f); return (f == 0) ? 1 : f; endfunction
  function automatic bit dly_hit(input int el, input int d); return (d == 0) || (el == d*TPU); endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_st = M_IDLE; m_code = 0; m_el = 0; m_live = 0;
    end else begin
      case (m_st)
        M_IDLE: if (en_i) begin m_st = M_SD; m_el = 0; m_code = 0; end
        M_SD: if (!en_i) begin m_st = M_PD; m_el = 0; end
          else if (tick_i) begin
            m_el++;
            if (dly_hit(m_el, int'(rise_cfg_i[15:10]))) begin m_st = M_UP; m_el = 0; m_live = 1; end
          end
        M_UP: if (!en_i) begin m_st = M_PD; m_el = 0; end
          else if (m_code >= int'(target_i)) begin m_code = target_i; m_st = M_ON; m_el = 0; end
          else if (tick_i) begin
            m_el++;
            if (m_el >= lim1(int'(rise_cfg_i[9:0]))) begin m_el = 0; m_code++; end
          end
        M_ON: if (!en_i) begin m_st = M_PD; m_el = 0; end
        M_PD: if (en_i) begin m_st = M_UP; m_el = 0; m_live = 1; end
          else if (tick_i) begin
            m_el++;
            if (dly_hit(m_el, int'(fall_cfg_i[15:10]))) begin m_st = M_DN; m_el = 0; end
          end
        M_DN: if (en_i) begin m_st = M_UP; m_el = 0; m_live = 1; end
          else if (m_code <= int'(thresh_i)) begin m_st = M_IDLE; m_code = 0; m_live = 0; m_el = 0; end
          else if (tick_i) begin
            m_el++;
            if (m_el >= lim1(int'(fall_cfg_i[9:0]))) begin m_el = 0; m_code--; end
          end
        default: m_st = M_IDLE;
      endcase
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk_i) if (rst_ni && !done) begin
    chk(int'(ref_o) == m_code, "R3 R5 R8 R9 ref_o", int'(ref_o), m_code);
    chk(pulse_en_o == m_live, "R6 pulse_en_o", pulse_en_o, m_live);
    chk(ss_active_o == ((m_st == M_SD) || (m_st == M_UP && m_code != int'(target_i))),
        "R7 ss_active_o", ss_active_o, ss_active_o ^ 1'b1);
  end

  always @(negedge clk_i) if (tick_mode != 0) tick_i <= ($urandom_range(0, 2) == 0);

  task automatic cyc(input int n); repeat (n) @(negedge clk_i); endtask

  // posedges until cond(sel) holds, sampled mid-cycle
  task automatic count_until(input int sel, input int val, output int n);
    n = 0;
    do begin
      @(posedge clk_i); n++; @(negedge clk_i);
    end while (!((sel == 0 && pulse_en_o == val[0]) || (sel == 1 && int'(ref_o) == val) ||
                 (sel == 2 && ss_active_o == val[0])) && n < 5000);
  endtask

  task automatic settle();
    en_i = 0;
    cyc(1);
    while (pulse_en_o || m_st != M_IDLE) cyc(1);
    cyc(2);
  endtask

  initial begin
    int n;
    void'($urandom(32'h0000_5a17));
    cyc(3);
    chk(ref_o == 0 && !pulse_en_o && !ss_active_o, "R1 reset outputs", {ref_o, pulse_en_o, ss_active_o}, 0);
    rst_ni = 1;
    cyc(2);
    chk(ref_o == 0 && !pulse_en_o && !ss_active_o, "R1 idle after reset", {ref_o, pulse_en_o, ss_active_o}, 0);

    // directed power-up / power-down
    rise_cfg_i = (16'd2 << 10) | 16'd3; fall_cfg_i = (16'd1 << 10);
    target_i = 4; thresh_i = 1;
    en_i = 1;
    count_until(0, 1, n); chk(n == 501, "R2 start delay posedges", n, 501);
    chk(ss_active_o == 1, "R7 ss high in up ramp", ss_active_o, 1);
    count_until(1, 4, n); chk(n == 12, "R3 ramp to target posedges", n, 12);
    chk(ss_active_o == 0, "R7 ss clear at target", ss_active_o, 0);
    cyc(40);
    chk(int'(ref_o) == 4 && pulse_en_o, "R3 hold at target", ref_o, 4);
    en_i = 0;
    count_until(1, 3, n); chk(n == 252, "R4 stop delay posedges", n, 252);
    count_until(0, 0, n); chk(n == 3, "R5 down to threshold", n, 3);
    chk(ref_o == 0, "R5 idle ref zero", ref_o, 0);

    // delay field 0 starts on first tick
    rise_cfg_i = 16'd0; target_i = 2;
    en_i = 1;
    count_until(0, 1, n); chk(n == 2, "R2 zero delay", n, 2);
    settle();

    // abort during start delay: pulses never start
    rise_cfg_i = (16'd1 << 10) | 16'd2; fall_cfg_i = 16'd0; target_i = 6; thresh_i = 0;
    en_i = 1; cyc(10); en_i = 0;
    @(posedge clk_i); @(negedge clk_i);
    chk(ss_active_o == 0, "R8 ss drops on abort", ss_active_o, 0);
    cyc(5);
    chk(!pulse_en_o && ref_o == 0, "R8 no pulses after abort", pulse_en_o, 0);

    // tick stall freezes the ramp, then re-enable during down ramp
    rise_cfg_i = 16'd1; fall_cfg_i = 16'd40; target_i = 10;
    en_i = 1;
    count_until(1, 5, n);
    tick_i = 0; cyc(40);
    chk(int'(ref_o) == 5, "R10 no advance without tick", ref_o, 5);
    tick_i = 1;
    count_until(1, 10, n);
    en_i = 0; cyc(100);
    chk(int'(ref_o) < 10 && pulse_en_o, "R5 down ramp running", ref_o, 9);
    en_i = 1;
    @(posedge clk_i); @(negedge clk_i);
    chk(ss_active_o && pulse_en_o, "R9 resume up ramp", ss_active_o, 1);
    count_until(1, 10, n); chk(n <= 4, "R9 resume without delay", n, 4);
    settle();

    // random episodes
    for (int ep = 0; ep < 40; ep++) begin
      rise_cfg_i = {6'($urandom_range(0, 2)), 10'($urandom_range(0, 5))};
      fall_cfg_i = {6'($urandom_range(0, 2)), 10'($urandom_range(0, 5))};
      target_i   = CW'($urandom_range(0, 20));
      thresh_i   = CW'($urandom_range(0, 4));
      tick_mode  = $urandom_range(0, 1);
      if (tick_mode == 0) tick_i = 1;
      for (int k = 0; k < 3; k++) begin
        en_i = 1; cyc($urandom_range(1, 700));
        en_i = 0; cyc($urandom_range(1, 500));
      end
      tick_mode = 0; tick_i = 1;
      settle();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    done = 1;
    fails++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule